// File: doc/BRIEF.md
# Operate-Instruction ALU Datapath

This block is the combinational execute stage for the three operate instructions of a 16-bit load/store processor: addition, bitwise AND and bitwise complement. It receives the current instruction word together with the two register values already read for it, decodes the 4-bit opcode, and forms the second operand. That operand is either the second register value or a small immediate carried in the instruction and sign-extended to the data width. The block then returns the 16-bit result and the index of the destination register.

It also exposes the two source register indices taken from the instruction, so a surrounding register file can be addressed from the same word. A valid flag marks words that carry an operate instruction. For every other opcode the flag is low and the result and destination index are held at zero, so a write-back stage can gate on the flag alone. The block holds no state and never addresses memory.

An elaboration parameter picks the adder structure: an explicit ripple-carry chain built by a generate loop, or a plain sum operator left to synthesis.

Top module: `operate_alu`

## Requirements
- R1: With opcode bits [15:12] = 0001 and mode bit [5] = 0, `alu_result` equals `src_a_val + src_b_val` modulo 2^16, and `op_valid` is 1.
- R2: With opcode 0001 and mode bit [5] = 1, `alu_result` equals `src_a_val` plus bits [4:0] sign-extended from bit 4, modulo 2^16.
- R3: With opcode 0101 and mode bit [5] = 0, `alu_result` equals `src_a_val & src_b_val`, and `op_valid` is 1.
- R4: With opcode 0101 and mode bit [5] = 1, `alu_result` equals `src_a_val` ANDed with bits [4:0] sign-extended from bit 4.
- R5: With opcode 1001, `alu_result` equals `~src_a_val` and `op_valid` is 1, whatever the values of `src_b_val` and of bits [5:0].
- R6: In register mode (bit [5] = 0), bits [4:3] of the instruction have no effect on `alu_result`.
- R7: For any of the other 13 opcodes, `op_valid` is 0 and both `alu_result` and `dst_index` are 0.
- R8: For the three operate opcodes, `dst_index` equals instruction bits [11:9], and it may name the same register as a source.
- R9: The immediate covers -16 to +15: a field of 11111 makes an addition decrement by one, 10000 subtracts 16 and 01111 adds 15.
- R10: `src_a_index` always equals instruction bits [8:6], and `src_b_index` always equals bits [2:0], whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Instruction word under execution |
| src_a_val | input | 16 | Value of the first source register |
| src_b_val | input | 16 | Value of the second source register |
| src_a_index | output | 3 | First source register index, for register-file read |
| src_b_index | output | 3 | Second source register index, for register-file read |
| alu_result | output | 16 | Operation result, zero when not valid |
| dst_index | output | 3 | Destination register index, zero when not valid |
| op_valid | output | 1 | High when the word carries an operate opcode |

## Verification
The bench sweeps all sixteen opcodes, both mode settings and all 32 values of the low five instruction bits against several operand pairs. The pairs include values that carry across the full width, values that wrap past the top bit and complementary bit patterns. This separates a correct sign extension from zero extension or a wrong sign bit, register mode from immediate mode, and the three operate opcodes from their one-bit neighbours. Varying `src_b_val` and bits [4:0] under the complement opcode shows that the second operand is ignored there, and the destination and source fields are varied together so that a swapped field position shows up.

// File: rtl/operate_alu_pkg.sv
package operate_alu_pkg;

   // Function chosen by the decoder
   typedef enum logic [1:0] {
      FN_NONE = 2'd0,
      FN_ADD  = 2'd1,
      FN_AND  = 2'd2,
      FN_INV  = 2'd3
   } alu_fn_e;

   // Fixed opcode encodings of the operate group
   localparam int unsigned OPC_W      = 4;
   localparam logic [3:0]  OPC_ADD    = 4'b0001;
   localparam logic [3:0]  OPC_AND    = 4'b0101;
   localparam logic [3:0]  OPC_INV    = 4'b1001;

   // Adder structure selectors
   localparam int unsigned ADDER_RIPPLE = 0;
   localparam int unsigned ADDER_INFER  = 1;

endpackage

// File: rtl/operate_alu_decode.sv
module operate_alu_decode
   import operate_alu_pkg::*;
#(
   parameter int unsigned IR_W  = 16,
   parameter int unsigned REG_W = 3,
   parameter int unsigned IMM_W = 5
) (
   input  logic [IR_W-1:0]  instr,
   output alu_fn_e          fn,
   output logic             imm_mode,
   output logic [REG_W-1:0] dst_field,
   output logic [REG_W-1:0] src_a_field,
   output logic [REG_W-1:0] src_b_field,
   output logic [IMM_W-1:0] imm_field
);

   localparam int unsigned OPC_LSB  = IR_W - OPC_W;
   localparam int unsigned DST_LSB  = OPC_LSB - REG_W;
   localparam int unsigned SRCA_LSB = DST_LSB - REG_W;
   localparam int unsigned MODE_BIT = SRCA_LSB - 1;

   generate
      if (MODE_BIT < IMM_W) begin : g_bad_layout
         $error("operate_alu_decode: immediate overlaps mode bit");
      end
      if (REG_W > IMM_W) begin : g_bad_reg
         $error("operate_alu_decode: register field wider than immediate field");
      end
   endgenerate

   logic [OPC_W-1:0] opc;

   assign opc         = instr[IR_W-1:OPC_LSB];
   assign dst_field   = instr[DST_LSB +: REG_W];
   assign src_a_field = instr[SRCA_LSB +: REG_W];
   assign imm_mode    = instr[MODE_BIT];
   assign imm_field   = instr[IMM_W-1:0];
   assign src_b_field = instr[REG_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_ADD: fn = FN_ADD;
         OPC_AND: fn = FN_AND;
         OPC_INV: fn = FN_INV;
         default: fn = FN_NONE;
      endcase
   end

   // Decoded function agrees with the raw opcode bits
   always_comb begin
      assert_fn_none_R7: assert ((fn == FN_NONE) ==
                                 !(opc == OPC_ADD || opc == OPC_AND || opc == OPC_INV))
         else $error("decode: function valid for a non-operate opcode");
   end

endmodule

// File: rtl/operate_alu_operand.sv
module operate_alu_operand #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IMM_W  = 5
) (
   input  logic [DATA_W-1:0] reg_val,
   input  logic [IMM_W-1:0]  imm_field,
   input  logic              imm_mode,
   output logic [DATA_W-1:0] operand
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   generate
      if (IMM_W < 2 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("operate_alu_operand: IMM_W must lie in [2, DATA_W)");
      end
   endgenerate

   logic [DATA_W-1:0] imm_ext;

   assign imm_ext = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};
   assign operand = imm_mode ? imm_ext : reg_val;

   // Extended immediate keeps its signed value
   always_comb begin
      if (imm_mode) begin
         assert_imm_signed_R9: assert ($signed(operand) == $signed(imm_field))
            else $error("operand: immediate value changed by extension");
      end
   end

endmodule

// File: rtl/operate_alu_exec.sv
module operate_alu_exec
   import operate_alu_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDER_KIND = ADDER_RIPPLE
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  alu_fn_e           fn,
   output logic [DATA_W-1:0] result
);

   generate
      if (ADDER_KIND != ADDER_RIPPLE && ADDER_KIND != ADDER_INFER) begin : g_bad_kind
         $error("operate_alu_exec: unknown ADDER_KIND");
      end
   endgenerate

   logic [DATA_W-1:0] sum;

   generate
      if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
         logic [DATA_W-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i] = opnd_a[i] ^ opnd_b[i] ^ carry[i];
            if (i < DATA_W - 1) begin : g_cy
               assign carry[i+1] = (opnd_a[i] & opnd_b[i]) |
                                   (carry[i] & (opnd_a[i] ^ opnd_b[i]));
            end
         end
      end else begin : g_infer
         assign sum = opnd_a + opnd_b;
      end
   endgenerate

   always_comb begin
      unique case (fn)
         FN_ADD:  result = sum;
         FN_AND:  result = opnd_a & opnd_b;
         FN_INV:  result = ~opnd_a;
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/operate_alu.sv
module operate_alu
   import operate_alu_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned IR_W       = 16,
   parameter int unsigned REG_W      = 3,
   parameter int unsigned IMM_W      = 5,
   parameter int unsigned ADDER_KIND = ADDER_RIPPLE
) (
   input  logic [IR_W-1:0]   instr_word,
   input  logic [DATA_W-1:0] src_a_val,
   input  logic [DATA_W-1:0] src_b_val,
   output logic [REG_W-1:0]  src_a_index,
   output logic [REG_W-1:0]  src_b_index,
   output logic [DATA_W-1:0] alu_result,
   output logic [REG_W-1:0]  dst_index,
   output logic              op_valid
);

   localparam int unsigned FIELD_BITS = OPC_W + 2 * REG_W + 1 + IMM_W;

   generate
      if (FIELD_BITS != IR_W) begin : g_bad_word
         $error("operate_alu: instruction fields do not fill IR_W");
      end
   endgenerate

   alu_fn_e           fn;
   logic              imm_mode;
   logic [REG_W-1:0]  dst_field;
   logic [IMM_W-1:0]  imm_field;
   logic [DATA_W-1:0] opnd_b;

   operate_alu_decode #(
      .IR_W  (IR_W),
      .REG_W (REG_W),
      .IMM_W (IMM_W)
   ) u_decode (
      .instr       (instr_word),
      .fn          (fn),
      .imm_mode    (imm_mode),
      .dst_field   (dst_field),
      .src_a_field (src_a_index),
      .src_b_field (src_b_index),
      .imm_field   (imm_field)
   );

   operate_alu_operand #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_operand (
      .reg_val   (src_b_val),
      .imm_field (imm_field),
      .imm_mode  (imm_mode),
      .operand   (opnd_b)
   );

   operate_alu_exec #(
      .DATA_W     (DATA_W),
      .ADDER_KIND (ADDER_KIND)
   ) u_exec (
      .opnd_a (src_a_val),
      .opnd_b (opnd_b),
      .fn     (fn),
      .result (alu_result)
   );

   assign op_valid  = (fn != FN_NONE);
   assign dst_index = op_valid ? dst_field : '0;

   // Port-level relations across decode, operand select and execute
   always_comb begin
      if (!op_valid) begin
         assert_idle_zero_R7: assert (alu_result == '0 && dst_index == '0)
            else $error("top: non-operate word produced output");
      end
      if (op_valid) begin
         assert_dst_field_R8: assert (dst_index == instr_word[IR_W-OPC_W-1 -: REG_W])
            else $error("top: destination index mismatch");
      end
      if (fn == FN_ADD && !imm_mode) begin
         assert_add_reg_R1: assert (alu_result == DATA_W'(src_a_val + src_b_val))
            else $error("top: register-mode sum mismatch");
      end
      if (fn == FN_INV) begin
         assert_invert_R5: assert (alu_result == ~src_a_val)
            else $error("top: complement mismatch");
      end
   end

endmodule

// File: tb/operate_alu_tb.sv
module operate_alu_tb;

   logic        clk = 1'b0;
   logic [15:0] instr_word = '0;
   logic [15:0] src_a_val  = '0;
   logic [15:0] src_b_val  = '0;
   logic [2:0]  src_a_index;
   logic [2:0]  src_b_index;
   logic [15:0] alu_result;
   logic [2:0]  dst_index;
   logic        op_valid;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   int unsigned cycles   = 0;
   bit          done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   operate_alu u_dut (
      .instr_word  (instr_word),
      .src_a_val   (src_a_val),
      .src_b_val   (src_b_val),
      .src_a_index (src_a_index),
      .src_b_index (src_b_index),
      .alu_result  (alu_result),
      .dst_index   (dst_index),
      .op_valid    (op_valid)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s instr=%h a=%h b=%h got=%h expected=%h",
                  tag, instr_word, src_a_val, src_b_val, got, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   logic [15:0] a_set [6] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hA5C3};
   logic [15:0] b_set [3] = '{16'h0001, 16'hFFFF, 16'h5A3C};

   initial begin
      // Idle state: all-zero word is opcode 0000, not an operate instruction
      @(negedge clk);
      #1;
      check("R7 idle valid",  {15'd0, op_valid}, 16'd0);
      check("R7 idle result", alu_result, 16'd0);

      for (int opc = 0; opc < 16; opc++) begin
         for (int mode = 0; mode < 2; mode++) begin
            for (int low = 0; low < 32; low++) begin
               for (int ai = 0; ai < 6; ai++) begin
                  for (int bi = 0; bi < 3; bi++) begin
                     logic [2:0]  dst, sa;
                     logic [15:0] sx, beff, exp_r;
                     logic        exp_v;
                     string       tag;
                     dst = 3'(low + ai);
                     sa  = 3'(opc + bi + mode);
                     @(negedge clk);
                     instr_word = {4'(opc), dst, sa, 1'(mode), 5'(low)};
                     src_a_val  = a_set[ai];
                     src_b_val  = b_set[bi];
                     sx   = {{11{low[4]}}, 5'(low)};
                     beff = (mode == 1) ? sx : src_b_val;
                     exp_v = 1'b1;
                     case (opc)
                        1: begin
                           exp_r = src_a_val + beff;
                           if (mode == 0) tag = "R1,R6";
                           else if (low == 31 || low == 16 || low == 15) tag = "R2,R9";
                           else tag = "R2";
                        end
                        5: begin
                           exp_r = src_a_val & beff;
                           tag = (mode == 0) ? "R3,R6" : "R4";
                        end
                        9: begin
                           exp_r = ~src_a_val;
                           tag = "R5";
                        end
                        default: begin
                           exp_r = '0;
                           exp_v = 1'b0;
                           tag = "R7";
                        end
                     endcase
                     #1;
                     check({tag, " result"}, alu_result, exp_r);
                     check({tag, " valid"}, {15'd0, op_valid}, {15'd0, exp_v});
                     check(exp_v ? "R8 dest" : "R7 dest", {13'd0, dst_index},
                           exp_v ? {13'd0, dst} : 16'd0);
                     check("R10 src_a", {13'd0, src_a_index}, {13'd0, sa});
                     check("R10 src_b", {13'd0, src_b_index}, {13'd0, 3'(low)});
                  end
               end
            end
         end
      end

      // R8: destination equal to source, decrement by immediate 11111 (R9)
      @(negedge clk);
      instr_word = {4'b0001, 3'd4, 3'd4, 1'b1, 5'b11111};
      src_a_val  = 16'h0000;
      #1;
      check("R9 decrement wraps", alu_result, 16'hFFFF);
      check("R8 dest same as src", {13'd0, dst_index}, 16'd4);

      // R6: register-mode bits [4:3] toggled, result unchanged
      @(negedge clk);
      instr_word = {4'b0001, 3'd1, 3'd2, 1'b0, 2'b11, 3'd3};
      src_a_val  = 16'h00F0;
      src_b_val  = 16'h000F;
      #1;
      check("R6 ignored bits", alu_result, 16'h00FF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule